// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block is a single interrupt controller for up to 64 request lines. It ranks every live request by two keys. The first is an interrupt level from 1 to 7. The second is a position within that level. It then drives the highest live level to the processor as a registered 3-bit code.

Sources 8 to 63 are programmable. Each has a small control register that sets its level and its priority within the level. Sources 1 to 7 are fixed external requests. Fixed source n always sits at level n, in a slot between programmable priorities 4 and 3. Source 0 is never used.

Software reaches the block through a word-addressed register port. Through it, software writes the mask and the control registers, and reads back the vector of the winner, either for one chosen level or for the whole controller. All reads are combinational and have no side effect.

Top module: `lvl_prio_intc`

## Requirements
- R1: After a synchronous reset, every source is masked, every control register reads 0, `irq_level` is 0, and both mask words read 0xFFFFFFFF.
- R2: A source whose mask bit is 1 never wins, even while its request line is high. Mask word address 0 holds sources 0 to 31 and address 1 holds sources 32 to 63, with bit i of a word mapping to source 32*word+i. Both words read back as written.
- R3: The control register of source s is at address 64+s. Bits [5:3] hold the level and bits [2:0] hold the priority. It reads back as written. For s from 0 to 7, the address reads 0 and writes are ignored.
- R4: A programmable source whose level field is 0 never takes part in arbitration.
- R5: `irq_level` is the highest level that has any unmasked pending request, or 0 when there is none. It is registered and reflects the requests and registers of the previous clock edge.
- R6: Within one level, a higher programmable priority value beats a lower one.
- R7: Fixed source n belongs to level n. It beats programmable priorities 3 to 0 of level n and loses to priorities 7 to 4 of level n.
- R8: When two programmable sources share the same level and priority, the lower source number wins.
- R9: A read of address 7+n, for n from 1 to 7, returns 64 plus the number of the winning source at level n. It returns the spurious vector 24 when nothing unmasked is pending at that level.
- R10: A read of address 15 returns the vector of the winner across all levels: the highest level first, then the rank within that level. It returns 24 when nothing is pending.
- R11: Acknowledge reads change no state. Repeated reads return the same vector, and `irq_level` is unaffected.
- R12: Source 0 never wins, whatever its request and mask bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 64 | Request lines, one per source, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Word address for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_level | output | 3 | Registered highest pending level, 0 when idle |

## Verification
The tests first apply a single request at a time, which confirms the level mapping and the vector encoding. They then place a programmable source at the same level as a fixed source, once above it and once below it, which separates the midpoint slot from a plain priority order. Two sources with identical settings check the tie break. Sources at different levels check that level dominates priority. Masked sources, a level-0 source and source 0 each check that ineligible requests are filtered out, and a behavioural reference model compares `irq_level` and the read data on every clock.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int LVL_W      = 3;
    localparam int PRI_W      = 3;
    localparam int SLOT_W     = PRI_W + 1;
    localparam int NUM_FIXED  = 7;
    localparam int FIXED_SLOT = 4;
    localparam int VEC_W      = 8;

    localparam logic [VEC_W-1:0] VEC_BASE     = 8'd64;
    localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;

    // word address map
    localparam int MASK_BASE  = 0;
    localparam int ACK_BASE   = 8;
    localparam int NUM_LVL    = 7;
    localparam int SWACK_ADDR = ACK_BASE + NUM_LVL;
    localparam int CTRL_BASE  = 64;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } src_cfg_t;

    // ordering key: level dominates, slot orders inside a level
    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic [SLOT_W-1:0] slot;
    } rank_t;

    // programmable priorities 4..7 move up one slot to leave room for the fixed source
    function automatic logic [SLOT_W-1:0] prio_to_slot(input logic [PRI_W-1:0] p);
        logic [SLOT_W-1:0] wide;
        wide = {1'b0, p};
        return (wide >= SLOT_W'(FIXED_SLOT)) ? wide + SLOT_W'(1) : wide;
    endfunction

endpackage

// File: rtl/ic_cfg_regs.sv
module ic_cfg_regs
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_SRC-1:0]         mask,
    output src_cfg_t [NUM_SRC-1:0]     cfg,
    output logic [DATA_W-1:0]          cfg_rdata
);
    localparam int MASK_WORDS = NUM_SRC / DATA_W;
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int CFG_W      = LVL_W + PRI_W;

    logic [DATA_W-1:0] mask_q [MASK_WORDS];
    logic [SRC_W-1:0]  cfg_sel;

    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[w] <= '1;
            end else if (wr_en && int'(addr) == MASK_BASE + w) begin
                mask_q[w] <= wdata;
            end
        end
        assign mask[w*DATA_W +: DATA_W] = mask_q[w];
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cfg
        if (s <= NUM_FIXED) begin : g_fixed
            assign cfg[s] = '0;
        end else begin : g_prog
            src_cfg_t cfg_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q <= '0;
                end else if (wr_en && int'(addr) == CTRL_BASE + s) begin
                    cfg_q <= src_cfg_t'(wdata[CFG_W-1:0]);
                end
            end
            assign cfg[s] = cfg_q;
        end
    end

    assign cfg_sel = addr[SRC_W-1:0];

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < MASK_WORDS; i++) begin
            if (int'(addr) == MASK_BASE + i) begin
                cfg_rdata = mask_q[i];
            end
        end
        if (int'(addr) >= CTRL_BASE && int'(addr) < CTRL_BASE + NUM_SRC) begin
            cfg_rdata = DATA_W'(cfg[cfg_sel]);
        end
    end

endmodule

// File: rtl/ic_rank_unit.sv
module ic_rank_unit
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]     req,
    input  logic [NUM_SRC-1:0]     mask,
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    output logic [NUM_SRC-1:0]     elig,
    output rank_t [NUM_SRC-1:0]    rank
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == 0) begin : g_none
            logic unused_src0;
            assign unused_src0 = ^{req[s], mask[s], cfg[s]};
            assign elig[s] = 1'b0;
            assign rank[s] = '0;
        end else if (s <= NUM_FIXED) begin : g_fixed
            logic unused_fixed_cfg;
            assign unused_fixed_cfg = ^cfg[s];
            assign elig[s] = req[s] & ~mask[s];
            assign rank[s] = '{lvl: LVL_W'(s), slot: SLOT_W'(FIXED_SLOT)};
        end else begin : g_prog
            assign elig[s] = req[s] & ~mask[s] & (cfg[s].lvl != '0);
            assign rank[s] = '{lvl: cfg[s].lvl, slot: prio_to_slot(cfg[s].pri)};
        end
    end

endmodule

// File: rtl/ic_pick.sv
module ic_pick
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]  elig,
    input  rank_t [NUM_SRC-1:0] rank,
    input  logic                filt_en,
    input  logic [LVL_W-1:0]    filt_lvl,
    output logic                found,
    output logic [SRC_W-1:0]    win_idx,
    output logic [LVL_W-1:0]    win_lvl
);
    rank_t best;

    // scanned from the top down; ">=" lets a lower index take over an equal key
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (elig[s] && (!filt_en || rank[s].lvl == filt_lvl) &&
                (!found || rank[s] >= best)) begin
                found   = 1'b1;
                best    = rank[s];
                win_idx = SRC_W'(s);
            end
        end
        win_lvl = best.lvl;
    end

endmodule

// File: rtl/lvl_prio_intc.sv
module lvl_prio_intc
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    localparam int ADDR_W = $clog2(CTRL_BASE + NUM_SRC),
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [LVL_W-1:0]   irq_level
);
    logic [NUM_SRC-1:0]     mask;
    src_cfg_t [NUM_SRC-1:0] cfg;
    logic [DATA_W-1:0]      cfg_rdata;
    logic [NUM_SRC-1:0]     elig;
    rank_t [NUM_SRC-1:0]    rank;

    logic                   g_found;
    logic [SRC_W-1:0]       g_idx;
    logic [LVL_W-1:0]       g_lvl;
    logic                   q_found;
    logic [SRC_W-1:0]       q_idx;
    logic [LVL_W-1:0]       q_lvl_unused;

    logic                   is_lvl_ack;
    logic                   is_sw_ack;
    logic [LVL_W-1:0]       q_lvl;
    logic [VEC_W-1:0]       lvl_vec;
    logic [VEC_W-1:0]       sw_vec;
    logic [LVL_W-1:0]       irq_level_q;

    ic_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .mask      (mask),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    ic_rank_unit #(.NUM_SRC(NUM_SRC)) u_rank (
        .req  (irq_req),
        .mask (mask),
        .cfg  (cfg),
        .elig (elig),
        .rank (rank)
    );

    ic_pick #(.NUM_SRC(NUM_SRC)) u_pick_all (
        .elig     (elig),
        .rank     (rank),
        .filt_en  (1'b0),
        .filt_lvl ('0),
        .found    (g_found),
        .win_idx  (g_idx),
        .win_lvl  (g_lvl)
    );

    // level acknowledge decode
    assign is_lvl_ack = (int'(addr) >= ACK_BASE) && (int'(addr) < ACK_BASE + NUM_LVL);
    assign is_sw_ack  = (int'(addr) == SWACK_ADDR);
    assign q_lvl      = is_lvl_ack ? LVL_W'(int'(addr) - ACK_BASE + 1) : '0;

    ic_pick #(.NUM_SRC(NUM_SRC)) u_pick_lvl (
        .elig     (elig),
        .rank     (rank),
        .filt_en  (1'b1),
        .filt_lvl (q_lvl),
        .found    (q_found),
        .win_idx  (q_idx),
        .win_lvl  (q_lvl_unused)
    );

    assign lvl_vec = q_found ? VEC_BASE + VEC_W'(q_idx) : VEC_SPURIOUS;
    assign sw_vec  = g_found ? VEC_BASE + VEC_W'(g_idx) : VEC_SPURIOUS;

    always_comb begin
        if (is_lvl_ack) begin
            rdata = DATA_W'(lvl_vec);
        end else if (is_sw_ack) begin
            rdata = DATA_W'(sw_vec);
        end else begin
            rdata = cfg_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_level_q <= '0;
        end else begin
            irq_level_q <= g_found ? g_lvl : '0;
        end
    end

    assign irq_level = irq_level_q;

endmodule

// File: rtl/ic_arb_checker.sv
module ic_arb_checker
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  rdata,
    input logic [LVL_W-1:0]   irq_level
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic is_ack;
    logic is_sw;
    assign is_ack = (int'(addr) >= ACK_BASE) && (int'(addr) <= SWACK_ADDR);
    assign is_sw  = (int'(addr) == SWACK_ADDR);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (irq_level == '0));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_req == '0) |=> (irq_level == '0));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($stable(irq_req) && !$past(wr_en)) |=> $stable(irq_level));

    p_ack_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        (is_ack && irq_req == '0) |-> (rdata == DATA_W'(VEC_SPURIOUS)));

    p_sw_live_r10: assert property (@(posedge clk) disable iff (rst)
        (is_sw && rdata != DATA_W'(VEC_SPURIOUS)) |->
            (rdata > DATA_W'(VEC_BASE) && rdata < DATA_W'(VEC_BASE) + DATA_W'(NUM_SRC)
             && irq_req[rdata[SRC_W-1:0]]));

    p_no_src0_r12: assert property (@(posedge clk) disable iff (rst)
        is_ack |-> (rdata != DATA_W'(VEC_BASE)));

endmodule

bind lvl_prio_intc ic_arb_checker #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq_level (irq_level)
);

// File: tb/tb_lvl_prio_intc.sv
module tb_lvl_prio_intc;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] req = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_mask [NSRC];
    int m_lvl  [NSRC];
    int m_pri  [NSRC];
    int exp_lvl = 0;

    lvl_prio_intc dut (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (req),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_level (irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl_of(int s);
        return (s <= 7) ? s : m_lvl[s];
    endfunction

    function automatic int key_of(int s);
        int sl;
        if (s <= 7) sl = 4;
        else sl = (m_pri[s] >= 4) ? m_pri[s] + 1 : m_pri[s];
        return lvl_of(s) * 16 + sl;
    endfunction

    // q == 0 means any level
    function automatic int best_src(int q);
        int best = -1;
        int bk = -1;
        for (int s = 1; s < NSRC; s++) begin
            if (req[s] && !m_mask[s] && lvl_of(s) != 0 && (q == 0 || lvl_of(s) == q)) begin
                if (key_of(s) > bk) begin
                    bk = key_of(s);
                    best = s;
                end
            end
        end
        return best;
    endfunction

    function automatic int vec_of(int s);
        return (s < 0) ? 24 : 64 + s;
    endfunction

    function automatic longint m_read(int a);
        longint v = 0;
        if (a == 0 || a == 1) begin
            for (int i = 0; i < 32; i++) if (m_mask[a*32 + i]) v = v | (longint'(1) << i);
        end else if (a >= 8 && a <= 14) begin
            v = vec_of(best_src(a - 7));
        end else if (a == 15) begin
            v = vec_of(best_src(0));
        end else if (a >= 64 && a < 128) begin
            if (a - 64 >= 8) v = m_lvl[a-64] * 8 + m_pri[a-64];
        end
        return v;
    endfunction

    function automatic string tag_of(int a);
        if (a <= 1) return "R2";
        if (a >= 8 && a <= 14) return "R9";
        if (a == 15) return "R10";
        if (a >= 64) return "R3";
        return "R1";
    endfunction

    // model update at each edge
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSRC; s++) begin
                m_mask[s] = 1'b1;
                m_lvl[s] = 0;
                m_pri[s] = 0;
            end
            exp_lvl = 0;
        end else begin
            int b;
            b = best_src(0);
            exp_lvl = (b < 0) ? 0 : lvl_of(b);
            if (wr_en) begin
                if (addr <= 1) begin
                    for (int i = 0; i < 32; i++) m_mask[addr*32 + i] = wdata[i];
                end else if (addr >= 72) begin
                    m_lvl[addr-64] = int'(wdata[5:3]);
                    m_pri[addr-64] = int'(wdata[2:0]);
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(irq_level == exp_lvl, "R5", irq_level, exp_lvl);
            chk(rdata == m_read(addr), tag_of(addr), rdata, m_read(addr));
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = 7'(a); wdata = 32'(d);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic set_req(input logic [63:0] v);
        @(posedge clk); #2;
        req = v;
        @(posedge clk); #2;
    endtask

    task automatic rd(input int a, input longint exp, input string tag);
        @(posedge clk); #2;
        addr = 7'(a);
        @(negedge clk);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic lvl_is(input int exp, input string tag);
        @(negedge clk);
        chk(irq_level == exp, tag, irq_level, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        rd(15, 24, "R1");
        rd(0, 64'hFFFF_FFFF, "R1");
        rd(1, 64'hFFFF_FFFF, "R1");
        rd(64 + 40, 0, "R1");
        lvl_is(0, "R1");

        // R2 all requests masked
        set_req('1);
        rd(15, 24, "R2");
        lvl_is(0, "R2");

        // unmask everything: only fixed sources have a level
        wr(0, 0);
        wr(1, 0);
        rd(15, 71, "R10");
        lvl_is(7, "R5");

        // R12 source 0 alone
        set_req(64'h1);
        rd(15, 24, "R12");
        lvl_is(0, "R12");

        // R4 level-0 programmable source
        wr(64 + 50, 7);
        set_req(64'h1 << 50);
        rd(15, 24, "R4");
        lvl_is(0, "R4");

        // R9 single programmable source at level 3
        wr(64 + 10, 26);
        set_req(64'h1 << 10);
        rd(10, 74, "R9");
        rd(9, 24, "R9");
        lvl_is(3, "R5");

        // R7 fixed source 3 beats priority 2, loses to priority 4
        set_req((64'h1 << 10) | (64'h1 << 3));
        rd(10, 67, "R7");
        wr(64 + 11, 28);
        set_req((64'h1 << 10) | (64'h1 << 3) | (64'h1 << 11));
        rd(10, 75, "R7");

        // R7 fixed source 2 beats priority 3 of level 2
        wr(64 + 30, 19);
        set_req((64'h1 << 2) | (64'h1 << 30));
        rd(9, 66, "R7");

        // R8 tie at level 5 priority 6
        wr(64 + 20, 46);
        wr(64 + 12, 46);
        set_req((64'h1 << 12) | (64'h1 << 20));
        rd(12, 76, "R8");

        // R6 priority 7 beats priority 6
        wr(64 + 40, 47);
        set_req((64'h1 << 12) | (64'h1 << 20) | (64'h1 << 40));
        rd(12, 104, "R6");
        lvl_is(5, "R5");

        // R10 level dominates priority
        set_req((64'h1 << 40) | (64'h1 << 7));
        rd(15, 71, "R10");
        rd(12, 104, "R9");
        lvl_is(7, "R10");

        // R2 mask source 7
        wr(0, 32'h80);
        rd(15, 104, "R2");
        rd(0, 32'h80, "R2");
        lvl_is(5, "R2");

        // R11 repeated acknowledge reads
        rd(15, 104, "R11");
        rd(15, 104, "R11");
        rd(12, 104, "R11");
        lvl_is(5, "R11");

        // R3 readback and ignored write to a fixed slot
        rd(64 + 40, 47, "R3");
        wr(64 + 5, 63);
        rd(64 + 5, 0, "R3");
        set_req(64'h1 << 5);
        rd(12, 69, "R3");
        lvl_is(5, "R3");

        set_req('0);
        lvl_is(0, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule